// File: doc/BRIEF.md
# Two-Channel Staged-Write DAC Code Register

This block sits on the host side of a pair of 12-bit digital-to-analog converters and turns byte-wide register writes into complete 12-bit converter codes. A 12-bit code is wider than one host write, so each channel has two write offsets. The lower offset loads a staging register with the eight least significant bits. The upper offset carries the top four bits and commits the whole code to the channel's output register in a single step.

Because nothing reaches the converter until the upper part is written, the converter never sees a half-updated code. Software must write the lower byte first and the upper byte second. If the upper byte is written first, the commit uses whatever lower byte was staged earlier. Each commit also raises a one-cycle update pulse for that channel.

The two channels are independent. Writes to any offset that is not one of the four channel offsets are ignored. None of the offsets can be read back.

Top module: `dual_dac_wlatch`

## Requirements
- R1: While reset is held, and at the first clock after reset is released, both channel codes are zero and both update pulses are low.
- R2: A write to offset 4 (channel 0) or offset 6 (channel 1) loads that channel's staging byte. It leaves both channel codes unchanged and raises no update pulse.
- R3: A write to offset 5 (channel 0) or offset 7 (channel 1) sets that channel's code, from the next clock on, to {write data bits 3..0, staged byte}. Write data bits 3..0 become code bits 11..8.
- R4: Write data bits 7..4 of an upper-part write have no effect on the code.
- R5: An upper-part write that comes without a fresh lower-byte write commits the staging byte left by the most recent lower-byte write, or zero if no lower-byte write has happened since reset.
- R6: A channel's update pulse is high for exactly the one clock that follows each upper-part write to that channel, and is low otherwise. Upper-part writes on consecutive cycles give a pulse on each of those cycles.
- R7: A write to one channel's offsets never changes the other channel's staging byte, code or update pulse.
- R8: A write to any offset other than 4, 5, 6 and 7 changes no code, no staging byte and no pulse.
- R9: With the write enable low, address and data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 4 | Register offset of the write |
| wr_data | input | 8 | Write data byte |
| dac_code | output | 24 | Channel codes; channel k occupies bits 12k+11..12k |
| dac_update | output | 2 | One-cycle commit pulse per channel; bit k is channel k |

## Verification
The bench drives three kinds of sequence:
- Lower byte then upper part. This is the normal order. It shows that the commit joins the nibble with the staged byte, and that the upper data bits are dropped.
- Upper part alone, or repeated upper parts. These tell the staged-byte reuse apart from a design that clears or skips the staging register, and they check that a pulse appears on every commit.
- Interleaved channel writes, out-of-range offsets and disabled writes. These separate true per-channel decoding from aliasing or a loose enable.

After a fixed set of directed cases, a long pseudo-random write stream is compared against the reference model on every clock.

// File: rtl/dac_wl_pkg.sv
package dac_wl_pkg;

   // Offset of the lower-byte staging write for channel ch
   function automatic int unsigned lo_offset(input int unsigned base, input int unsigned ch);
      return base + 2 * ch;
   endfunction

   // Offset of the upper-part commit write for channel ch
   function automatic int unsigned hi_offset(input int unsigned base, input int unsigned ch);
      return base + 2 * ch + 1;
   endfunction

endpackage

// File: rtl/dac_wl_decode.sv
module dac_wl_decode
   import dac_wl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BASE_OFS = 4,
   parameter int unsigned NUM_CH   = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [NUM_CH-1:0] lo_sel,
   output logic [NUM_CH-1:0] hi_sel
);

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
         localparam int unsigned LO_A = lo_offset(BASE_OFS, k);
         localparam int unsigned HI_A = hi_offset(BASE_OFS, k);
         assign lo_sel[k] = wr_en && (wr_addr == ADDR_W'(LO_A));
         assign hi_sel[k] = wr_en && (wr_addr == ADDR_W'(HI_A));
      end
   endgenerate

endmodule

// File: rtl/dac_wl_channel.sv
module dac_wl_channel #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [CODE_W-1:0] code_o,
   output logic              upd_o
);

   localparam int unsigned HI_W = CODE_W - BYTE_W;

   logic [BYTE_W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         code_o  <= '0;
         upd_o   <= 1'b0;
      end else begin
         upd_o <= hi_wr;
         if (lo_wr) stage_q <= wr_data;
         if (hi_wr) code_o <= {wr_data[HI_W-1:0], stage_q};
      end
   end

   // R2
   stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> ($stable(code_o) && !upd_o));

   // R3
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> (code_o[CODE_W-1:BYTE_W] == $past(wr_data[HI_W-1:0])));

   // R6
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_wr |=> (!upd_o && $stable(code_o)));

endmodule

// File: rtl/dual_dac_wlatch.sv
module dual_dac_wlatch
   import dac_wl_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BASE_OFS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [BYTE_W-1:0]        wr_data,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_update
);

   localparam int unsigned LAST_OFS = BASE_OFS + 2 * NUM_CH - 1;

   initial begin
      assert (CODE_W > BYTE_W) else $error("code must be wider than one byte");
      assert (CODE_W <= 2 * BYTE_W) else $error("code must fit in two writes");
      assert (LAST_OFS < (1 << ADDR_W)) else $error("offsets exceed address space");
      assert (NUM_CH >= 1) else $error("need at least one channel");
   end

   logic [NUM_CH-1:0] lo_sel, hi_sel;

   dac_wl_decode #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS), .NUM_CH(NUM_CH)) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .lo_sel (lo_sel),
      .hi_sel (hi_sel)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         dac_wl_channel #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .lo_wr  (lo_sel[k]),
            .hi_wr  (hi_sel[k]),
            .wr_data(wr_data),
            .code_o (dac_code[k*CODE_W +: CODE_W]),
            .upd_o  (dac_update[k])
         );
      end
   endgenerate

   // R7
   single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dac_update));

   // R8
   foreign_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((int'(wr_addr) < BASE_OFS) || (int'(wr_addr) > LAST_OFS)))
         |=> ($stable(dac_code) && (dac_update == '0)));

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(dac_code) && (dac_update == '0)));

endmodule

// File: tb/test_dual_dac_wlatch.sv
module test_dual_dac_wlatch;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [23:0] dac_code;
   logic [1:0]  dac_update;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_stage[2];
   int m_code[2];
   int m_upd[2];

   always #(CLK_P/2) clk = ~clk;

   dual_dac_wlatch i_dual_dac_wlatch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dac_code(dac_code), .dac_update(dac_update)
   );

   task automatic compare(input string tag);
      for (int k = 0; k < 2; k++) begin
         int got_c = int'(dac_code[k*12 +: 12]);
         int got_u = int'(dac_update[k]);
         checks++;
         if (got_c != m_code[k]) begin
            errors++;
            $display("FAIL %s ch%0d code actual=%03h expected=%03h", tag, k, got_c, m_code[k]);
         end
         checks++;
         if (got_u != m_upd[k]) begin
            errors++;
            $display("FAIL %s ch%0d update actual=%0d expected=%0d", tag, k, got_u, m_upd[k]);
         end
      end
   endtask

   // drive one cycle at negedge, model the edge, compare at the next negedge
   task automatic step(input bit en, input int addr, input int data, input string tag);
      wr_en = en; wr_addr = 4'(addr); wr_data = 8'(data);
      @(negedge clk);
      m_upd[0] = 0; m_upd[1] = 0;
      if (en) begin
         for (int k = 0; k < 2; k++) begin
            if (addr == 4 + 2*k) m_stage[k] = data & 8'hFF;
            if (addr == 5 + 2*k) begin
               m_code[k] = ((data & 4'hF) << 8) | m_stage[k];
               m_upd[k] = 1;
            end
         end
      end
      compare(tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 7;
      for (int k = 0; k < 2; k++) begin
         m_stage[k] = 0; m_code[k] = 0; m_upd[k] = 0;
      end
      @(negedge clk);
      compare("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, "R1 after release");

      // R5: upper part with nothing staged commits zero low byte
      step(1, 5, 8'h03, "R5 fresh stage");
      // R2 then R3: normal order, channel 0
      step(1, 4, 8'hA5, "R2 stage ch0");
      step(1, 5, 8'h07, "R3 commit ch0");
      // R4: upper data bits ignored
      step(1, 5, 8'hF2, "R4 upper bits");
      // R5: stale reuse after a previous commit
      step(1, 5, 8'h09, "R5 stale reuse");
      // R6: back-to-back commits, then idle
      step(1, 7, 8'h01, "R6 pulse a");
      step(1, 7, 8'h02, "R6 pulse b");
      step(0, 0, 0, "R6 pulse end");
      // R7: channel 1 staging does not touch channel 0
      step(1, 6, 8'h3C, "R7 stage ch1");
      step(1, 7, 8'hBE, "R7 commit ch1");
      step(1, 5, 8'h00, "R7 ch0 keeps own stage");
      // R8: foreign offsets, including 3 and 8, then check staging via commit
      for (int a = 0; a < 16; a++)
         if (a < 4 || a > 7) step(1, a, 8'hFF, "R8 foreign offset");
      step(1, 5, 8'h01, "R8 stage kept ch0");
      step(1, 7, 8'h01, "R8 stage kept ch1");
      // R9: disabled writes to live offsets
      step(0, 4, 8'h11, "R9 idle lo");
      step(0, 5, 8'h0F, "R9 idle hi");
      step(1, 5, 8'h0E, "R9 stage kept");
      // random stream
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom(seed + i);
         step(r[0] | r[1], (r >> 2) & 15, (r >> 8) & 255, "R3 R6 R7 random");
      end
      // R1: reset clears state
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         m_stage[k] = 0; m_code[k] = 0; m_upd[k] = 0;
      end
      compare("R1 second reset");
      rst_n = 1'b1;
      step(1, 7, 8'h04, "R1 stage cleared");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule